// File: doc/BRIEF.md
# Compressed-Sensing Column Selection Sequencer

This controller drives the column-side selection network of a column-parallel image readout that takes random linear measurements instead of plain pixel values. The pixel array is split into square tiles of 16x16 pixels. Several tiles are read at the same time. For each tile row the sequencer presents eight of the sixteen tile columns one after another. Each presented pixel either reaches a converter input or is replaced by a reference level, and a pseudo-random bit decides which. All tiles share one binary measurement matrix. A lane that serves a different tile sees a rotated copy of the one-hot column code.

A frame is split into passes. Each pass of a tile group is run twice with an identical pattern: first on reset levels, then on signal levels, so that digital correlated double sampling can subtract the two. The sequencer then moves to the next tile group in the tile row, and after that to the next tile row. The compression mode sets how many tiles share the converters: 4, 8 or 16 tiles, which gives 64, 32 or 16 samples per tile. A bypass mode sends every column straight to its own converter. The mode is captured once, when the frame starts.

Top module: `csq_sequencer`

## Requirements
- R1: While reset is asserted and until the first accepted frame request, busy, conv_start, sample_valid, frame_done and pass_sig are 0, and col_sel and conv_gate are all zero.
- R2: A frame_start pulse seen while idle latches cr_mode and starts a frame. The encodings are 0 = bypass, 1 = 1/4, 2 = 1/8 and 3 = 1/16. conv_start goes high in the next cycle. A frame_start pulse or a change of cr_mode while busy has no effect on the running frame.
- R3: Walk order in a frame: tile rows 0..15 in turn. Within a tile row, tile groups 0..(16/G − 1) in turn, where G is 4, 8, 16 or 16 for modes 1, 2, 3 or 0. Within a group, a reset pass (pass_sig=0) comes first and a signal pass (pass_sig=1) follows. blk_row and grp_idx report the current position.
- R4: In a compression mode, a pass has 16 pixel rows. Each pixel row has 8 scan cycles, numbered k = 0..7. In scan cycle k, lane l (bits 16l..16l+15 of col_sel) carries a one-hot code with bit (2k + l) mod 16 set for l < G. Lanes l ≥ G are zero.
- R5: In a compression mode, conv_gate[c] equals bit (c mod 64) of a 64-bit Galois LFSR. The LFSR shifts left and XORs 0x1B into the state whenever the bit shifted out is 1. It is loaded with SEED in each conv_start cycle and advances once per scan cycle, so scan cycle 0 uses SEED itself.
- R6: The signal pass of a group repeats the reset pass of that group exactly: the same column codes and the same gate bits in every scan cycle.
- R7: In bypass mode, each pixel row takes one scan cycle. In that cycle col_sel and conv_gate are all ones, and one group covers all 16 tiles.
- R8: conv_start is high for exactly one cycle, directly before the first scan cycle of every pass. sample_valid is high exactly in the scan cycles, and pix_row gives the pixel row. Outside the scan cycles, col_sel and conv_gate are zero.
- R9: frame_done is high for one cycle, directly after the last scan cycle of a frame. busy is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame request pulse (accepted only when idle) |
| cr_mode | input | 2 | Compression mode: 0 bypass, 1 quarter, 2 eighth, 3 sixteenth |
| busy | output | 1 | A frame is in progress |
| conv_start | output | 1 | Converter start pulse before each pass |
| sample_valid | output | 1 | Scan cycle: col_sel and conv_gate are meaningful |
| pass_sig | output | 1 | 0 = reset-level pass, 1 = signal-level pass |
| blk_row | output | 4 | Current tile row |
| grp_idx | output | 4 | Current tile group in the row |
| pix_row | output | 4 | Pixel row within the tile |
| col_sel | output | 256 | Per-lane 16-bit column codes, lane l at bits 16l+15..16l |
| conv_gate | output | 256 | Per-converter pass/reference select (1 = pixel) |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The bench uses the default geometry: a 256-wide array, 16x16 tiles and a 64-bit generator. This gives the full set of group sizes, 4, 8 and 16 tiles, so every mode runs complete frames. Lane rotation is checked across all sixteen lanes at 1/16, and gate bits fold modulo 64 over all 256 converters. One fixed SEED is shared by the bench model and the design, so every scan cycle of every pass is compared bit for bit. The reseed is also covered, because the signal pass must repeat the reset pass.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [1:0] {
        CR_FULL      = 2'd0,
        CR_QUARTER   = 2'd1,
        CR_EIGHTH    = 2'd2,
        CR_SIXTEENTH = 2'd3
    } cr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SCAN = 2'd2,
        ST_FIN  = 2'd3
    } walk_state_e;

    localparam logic [63:0] PRBS_TAPS = 64'h1B;

    // tiles that share the converter bank in one group
    function automatic int unsigned tiles_per_group(cr_mode_e m, int unsigned ntile);
        case (m)
            CR_QUARTER:   return 4;
            CR_EIGHTH:    return 8;
            CR_SIXTEENTH: return 16;
            default:      return ntile;
        endcase
    endfunction

    function automatic int unsigned groups_per_row(cr_mode_e m, int unsigned ntile);
        case (m)
            CR_QUARTER:   return ntile / 4;
            CR_EIGHTH:    return ntile / 8;
            CR_SIXTEENTH: return ntile / 16;
            default:      return 1;
        endcase
    endfunction

    function automatic int unsigned scans_per_row(cr_mode_e m, int unsigned tile_dim);
        return (m == CR_FULL) ? 1 : tile_dim / 2;
    endfunction

    function automatic logic [63:0] prbs_next(logic [63:0] s);
        return {s[62:0], 1'b0} ^ (s[63] ? PRBS_TAPS : 64'h0);
    endfunction

endpackage

// File: rtl/csq_prbs.sv
module csq_prbs
    import csq_pkg::*;
#(
    parameter logic [63:0] SEED = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reseed,
    input  logic        advance,
    output logic [63:0] state
);
    always_ff @(posedge clk) begin
        if (rst || reseed)
            state <= SEED;
        else if (advance)
            state <= prbs_next(state);
    end
endmodule

// File: rtl/csq_walker.sv
module csq_walker
    import csq_pkg::*;
#(
    parameter int unsigned NTILE    = 16,
    parameter int unsigned TILE_DIM = 16,
    localparam int unsigned RW = $clog2(TILE_DIM),
    localparam int unsigned SW = $clog2(TILE_DIM / 2),
    localparam int unsigned BW = $clog2(NTILE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  cr_mode_e          mode_in,
    output cr_mode_e          mode_q,
    output walk_state_e       st_q,
    output logic              pass_q,
    output logic [RW-1:0]     row_q,
    output logic [SW-1:0]     step_q,
    output logic [BW-1:0]     grp_q,
    output logic [BW-1:0]     brow_q
);
    localparam logic [RW-1:0] ROW_END  = RW'(TILE_DIM - 1);
    localparam logic [BW-1:0] BROW_END = BW'(NTILE - 1);

    logic [SW-1:0] step_end;
    logic [BW-1:0] grp_end;
    logic          pass_end;

    always_comb begin
        step_end = SW'(scans_per_row(mode_q, TILE_DIM) - 1);
        grp_end  = BW'(groups_per_row(mode_q, NTILE) - 1);
        pass_end = (step_q == step_end) && (row_q == ROW_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= CR_FULL;
            pass_q <= 1'b0;
            row_q  <= '0;
            step_q <= '0;
            grp_q  <= '0;
            brow_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (frame_start) begin
                    st_q   <= ST_ARM;
                    mode_q <= mode_in;
                    pass_q <= 1'b0;
                    row_q  <= '0;
                    step_q <= '0;
                    grp_q  <= '0;
                    brow_q <= '0;
                end
                ST_ARM: st_q <= ST_SCAN;
                ST_SCAN: begin
                    if (step_q != step_end) begin
                        step_q <= step_q + 1'b1;
                    end else begin
                        step_q <= '0;
                        row_q  <= (row_q == ROW_END) ? '0 : row_q + 1'b1;
                    end
                    if (pass_end) begin
                        if (!pass_q) begin
                            pass_q <= 1'b1;
                            st_q   <= ST_ARM;
                        end else if (grp_q != grp_end) begin
                            pass_q <= 1'b0;
                            grp_q  <= grp_q + 1'b1;
                            st_q   <= ST_ARM;
                        end else if (brow_q != BROW_END) begin
                            pass_q <= 1'b0;
                            grp_q  <= '0;
                            brow_q <= brow_q + 1'b1;
                            st_q   <= ST_ARM;
                        end else begin
                            st_q   <= ST_FIN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/csq_lane_map.sv
module csq_lane_map
    import csq_pkg::*;
#(
    parameter int unsigned NTILE    = 16,
    parameter int unsigned TILE_DIM = 16,
    parameter int unsigned NCONV    = 256,
    localparam int unsigned RW = $clog2(TILE_DIM),
    localparam int unsigned SW = $clog2(TILE_DIM / 2)
) (
    input  logic                        scan,
    input  cr_mode_e                    mode,
    input  logic [SW-1:0]               step,
    input  logic [63:0]                 prbs,
    output logic [NTILE*TILE_DIM-1:0]   col_sel,
    output logic [NCONV-1:0]            gate
);
    localparam logic [TILE_DIM-1:0] ONE = TILE_DIM'(1);

    logic        full;
    logic [31:0] gsize;

    always_comb begin
        full  = (mode == CR_FULL);
        gsize = 32'(tiles_per_group(mode, NTILE));
    end

    for (genvar l = 0; l < NTILE; l++) begin : g_lane
        logic [RW-1:0] pos;
        logic          lane_on;
        always_comb begin
            // power-of-two tile width: the add wraps modulo TILE_DIM
            pos     = RW'({step, 1'b0}) + RW'(l);
            lane_on = (32'(l) < gsize);
            if (!scan)
                col_sel[l*TILE_DIM +: TILE_DIM] = '0;
            else if (full)
                col_sel[l*TILE_DIM +: TILE_DIM] = '1;
            else if (lane_on)
                col_sel[l*TILE_DIM +: TILE_DIM] = ONE << pos;
            else
                col_sel[l*TILE_DIM +: TILE_DIM] = '0;
        end
    end

    for (genvar c = 0; c < NCONV; c++) begin : g_conv
        assign gate[c] = scan & (full | prbs[c % 64]);
    end
endmodule

// File: rtl/csq_sequencer.sv
module csq_sequencer
    import csq_pkg::*;
#(
    parameter int unsigned ARRAY_DIM = 256,
    parameter int unsigned TILE_DIM  = 16,
    parameter logic [63:0] SEED      = 64'h9E37_79B9_7F4A_7C15,
    localparam int unsigned NTILE = ARRAY_DIM / TILE_DIM,
    localparam int unsigned RW    = $clog2(TILE_DIM),
    localparam int unsigned BW    = $clog2(NTILE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [1:0]           cr_mode,
    output logic                 busy,
    output logic                 conv_start,
    output logic                 sample_valid,
    output logic                 pass_sig,
    output logic [BW-1:0]        blk_row,
    output logic [BW-1:0]        grp_idx,
    output logic [RW-1:0]        pix_row,
    output logic [ARRAY_DIM-1:0] col_sel,
    output logic [ARRAY_DIM-1:0] conv_gate,
    output logic                 frame_done
);
    localparam int unsigned SW = $clog2(TILE_DIM / 2);

    cr_mode_e    mode_q;
    walk_state_e st_q;
    logic        pass_q;
    logic [RW-1:0] row_q;
    logic [SW-1:0] step_q;
    logic [BW-1:0] grp_q;
    logic [BW-1:0] brow_q;
    logic [63:0]   prbs;

    csq_walker #(.NTILE(NTILE), .TILE_DIM(TILE_DIM)) i_walker (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .mode_in(cr_mode_e'(cr_mode)), .mode_q(mode_q), .st_q(st_q),
        .pass_q(pass_q), .row_q(row_q), .step_q(step_q),
        .grp_q(grp_q), .brow_q(brow_q)
    );

    csq_prbs #(.SEED(SEED)) i_prbs (
        .clk(clk), .rst(rst), .reseed(st_q == ST_ARM),
        .advance(st_q == ST_SCAN), .state(prbs)
    );

    csq_lane_map #(.NTILE(NTILE), .TILE_DIM(TILE_DIM), .NCONV(ARRAY_DIM)) i_lane_map (
        .scan(st_q == ST_SCAN), .mode(mode_q), .step(step_q), .prbs(prbs),
        .col_sel(col_sel), .gate(conv_gate)
    );

    assign busy         = (st_q != ST_IDLE);
    assign conv_start   = (st_q == ST_ARM);
    assign sample_valid = (st_q == ST_SCAN);
    assign frame_done   = (st_q == ST_FIN);
    assign pass_sig     = pass_q;
    assign blk_row      = brow_q;
    assign grp_idx      = grp_q;
    assign pix_row      = row_q;
endmodule

// File: rtl/csq_checker.sv
module csq_checker
    import csq_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         busy,
    input logic         conv_start,
    input logic         sample_valid,
    input logic         pass_sig,
    input logic         frame_done,
    input logic [255:0] col_sel,
    input logic [255:0] conv_gate,
    input cr_mode_e     mode_q
);
    a_r8_start_then_scan: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> sample_valid && !conv_start);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(conv_start && sample_valid));

    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !busy);

    a_r9_done_after_scan: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(sample_valid));

    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(mode_q));

    a_r3_pass_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pass_sig) |-> conv_start);

    a_r3_pass_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pass_sig) |-> conv_start);

    a_r4_lane0_onehot: assert property (@(posedge clk) disable iff (rst)
        sample_valid && mode_q != CR_FULL |-> $countones(col_sel[15:0]) == 1);

    a_r7_bypass_all: assert property (@(posedge clk) disable iff (rst)
        sample_valid && mode_q == CR_FULL |-> (&conv_gate) && (&col_sel));
endmodule

bind csq_sequencer csq_checker i_csq_checker (
    .clk(clk), .rst(rst), .busy(busy), .conv_start(conv_start),
    .sample_valid(sample_valid), .pass_sig(pass_sig), .frame_done(frame_done),
    .col_sel(col_sel), .conv_gate(conv_gate), .mode_q(mode_q)
);

// File: tb/test_csq_sequencer.sv
module test_csq_sequencer;
    localparam logic [63:0] SEED = 64'h9E37_79B9_7F4A_7C15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_start = 1'b0;
    logic [1:0]   cr_mode = 2'd0;
    logic         busy, conv_start, sample_valid, pass_sig, frame_done;
    logic [3:0]   blk_row, grp_idx, pix_row;
    logic [255:0] col_sel, conv_gate;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    csq_sequencer #(.ARRAY_DIM(256), .TILE_DIM(16), .SEED(SEED)) i_csq_sequencer (
        .clk(clk), .rst(rst), .frame_start(frame_start), .cr_mode(cr_mode),
        .busy(busy), .conv_start(conv_start), .sample_valid(sample_valid),
        .pass_sig(pass_sig), .blk_row(blk_row), .grp_idx(grp_idx),
        .pix_row(pix_row), .col_sel(col_sel), .conv_gate(conv_gate),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int gsize(int m);
        case (m) 1: return 4; 2: return 8; default: return 16; endcase
    endfunction

    function automatic logic [63:0] lfsr_nx(logic [63:0] s);
        return {s[62:0], 1'b0} ^ (s[63] ? 64'h1B : 64'h0);
    endfunction

    function automatic logic [255:0] exp_col(int m, int k);
        logic [255:0] r = '0;
        for (int l = 0; l < 16; l++) begin
            if (m == 0) r[l*16 +: 16] = 16'hFFFF;
            else if (l < gsize(m)) r[l*16 + ((2*k + l) % 16)] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [255:0] exp_gate(int m, logic [63:0] s);
        logic [255:0] r;
        for (int c = 0; c < 256; c++) r[c] = (m == 0) ? 1'b1 : s[c % 64];
        return r;
    endfunction

    // one full frame; disturb = pulse frame_start and change cr_mode mid-frame
    task automatic run_frame(input int m, input bit disturb);
        int steps;
        int groups;
        logic [63:0] s;
        logic [255:0] first_gate [16][8];
        steps  = (m == 0) ? 1 : 8;
        groups = 16 / gsize(m);
        @(negedge clk);
        cr_mode = 2'(m);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int br = 0; br < 16; br++)
            for (int g = 0; g < groups; g++)
                for (int p = 0; p < 2; p++) begin
                    chk(conv_start === 1'b1 && sample_valid === 1'b0, "R8 start pulse",
                        {conv_start, sample_valid}, 2'b10);
                    chk(col_sel === '0 && conv_gate === '0, "R8 idle outputs zero",
                        col_sel | conv_gate, '0);
                    chk(pass_sig === p[0] && blk_row === 4'(br) && grp_idx === 4'(g),
                        "R3 walk order", {pass_sig, blk_row, grp_idx},
                        {p[0], 4'(br), 4'(g)});
                    s = SEED;
                    @(negedge clk);
                    for (int r = 0; r < 16; r++)
                        for (int k = 0; k < steps; k++) begin
                            chk(sample_valid === 1'b1 && conv_start === 1'b0 &&
                                pix_row === 4'(r), "R8 scan cycle",
                                {sample_valid, pix_row}, {1'b1, 4'(r)});
                            chk(col_sel === exp_col(m, k), m == 0 ? "R7 bypass col_sel" :
                                "R4 column codes", col_sel, exp_col(m, k));
                            chk(conv_gate === exp_gate(m, s), m == 0 ? "R7 bypass gate" :
                                "R5 gate bits", conv_gate, exp_gate(m, s));
                            if (p == 0) first_gate[r][k] = conv_gate;
                            else if (br == 0 && g == 0)
                                chk(conv_gate === first_gate[r][k], "R6 signal pass repeats",
                                    conv_gate, first_gate[r][k]);
                            s = lfsr_nx(s);
                            if (disturb && br == 0 && g == 0 && p == 0 && r == 0 && k == 0) begin
                                cr_mode = 2'(m ^ 1);
                                frame_start = 1'b1;
                            end else begin
                                frame_start = 1'b0;
                            end
                            @(negedge clk);
                        end
                end
        chk(frame_done === 1'b1 && sample_valid === 1'b0, "R9 done pulse",
            {frame_done, sample_valid}, 2'b10);
        @(negedge clk);
        chk(busy === 1'b0 && frame_done === 1'b0, "R9 idle after done",
            {busy, frame_done}, 2'b00);
    endtask

    initial begin : main
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && conv_start === 1'b0 && sample_valid === 1'b0 &&
            frame_done === 1'b0 && pass_sig === 1'b0, "R1 reset state",
            {busy, conv_start, sample_valid, frame_done, pass_sig}, '0);
        chk(col_sel === '0 && conv_gate === '0, "R1 reset outputs", col_sel | conv_gate, '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && conv_start === 1'b0, "R1 idle after reset",
            {busy, conv_start}, '0);
        run_frame(1, 1'b1);   // R2: mid-frame request and mode change ignored
        run_frame(2, 1'b0);
        run_frame(3, 1'b1);
        run_frame(0, 1'b1);
        for (int i = 0; i < 2; i++) begin
            int gap;
            gap = int'($urandom_range(1, 20));
            repeat (gap) @(negedge clk);
            run_frame(int'($urandom_range(0, 3)), 1'(($urandom_range(0, 1))));
        end
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule